// File: doc/BRIEF.md
# Floating-Point Exception Flag Register

This block holds the floating-point status flags of a 32-bit processor's FPU. Each time an arithmetic operation finishes, the datapath pulses a completion strobe and presents a vector of raw exception indications. The block then sets the matching sticky flags and rewrites a summary bit that reflects only that latest operation. Two of the flags are fed by a single indication: output-denormal raises both the underflow flag and the inexact flag.

Software can also load the flags directly through an update-flags strobe with a 16-bit operand. The upper byte of the operand is a mask and the lower byte holds values. Most flags load as the AND of a mask bit and a value bit. The inexact flag is different: it changes only when its own mask bit is set.

All flags are registered and read out in parallel. A change becomes visible on the clock edge that samples the strobe.

Top module: `fpflag_unit`

## Requirements
- R1: While `rst` is high, and after it is released with no strobe, all six flag outputs are 0.
- R2: On an operation, `op_exc` bit 0 (invalid) sets `fl_invalid`. Bit 1 (overflow) sets `fl_overflow`. Bit 4 (divide-by-zero) sets `fl_divzero`.
- R3: On an operation, `op_exc` bit 2 (underflow) or bit 3 (output-denormal) sets `fl_underflow`.
- R4: On an operation, `op_exc` bit 5 (inexact) or bit 3 (output-denormal) sets `fl_inexact`.
- R5: On every operation, `fl_summary` is written with 1 if any of `op_exc` bits 5..0 is set, and with 0 otherwise.
- R6: `op_exc` bit 6 (input-denormal) has no effect on any flag. An operation carrying only that bit leaves the sticky flags unchanged and writes `fl_summary` to 0.
- R7: `fl_invalid`, `fl_overflow`, `fl_divzero`, `fl_underflow` and `fl_inexact` are never cleared by an operation. Only reset or update-flags clears them.
- R8: Update-flags loads each of these flags with its value bit ANDed with its mask bit:
  - `fl_summary` = bit 7 & bit 15
  - `fl_invalid` = bit 6 & bit 14
  - `fl_overflow` = bit 5 & bit 13
  - `fl_divzero` = bit 4 & bit 12
  - `fl_underflow` = bit 3 & bit 11
- R9: Update-flags changes `fl_inexact` only when operand bit 10 is 1, and then loads it with bit 2. When bit 10 is 0, `fl_inexact` keeps its value.
- R10: When `op_done` and `upd_valid` are high in the same cycle, only the update-flags takes effect.
- R11: Flags change on the clock edge that samples a strobe. With neither strobe high, all flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | Operation-complete strobe |
| op_exc | input | 7 | Exception indications: 0 invalid, 1 overflow, 2 underflow, 3 output-denormal, 4 divide-by-zero, 5 inexact, 6 input-denormal |
| upd_valid | input | 1 | Update-flags strobe |
| upd_operand | input | 16 | Update-flags operand: mask in bits 15..8, values in bits 7..0 |
| fl_summary | output | 1 | Summary flag |
| fl_invalid | output | 1 | Sticky invalid flag |
| fl_overflow | output | 1 | Sticky overflow flag |
| fl_divzero | output | 1 | Sticky divide-by-zero flag |
| fl_underflow | output | 1 | Sticky underflow flag |
| fl_inexact | output | 1 | Sticky inexact flag |

## Verification
The assertions assume that `op_exc` and `upd_operand` hold known values in every cycle where their strobe is high. They also assume that the strobes themselves are never unknown once reset is released. The bench drives every input to a defined value from time zero and changes inputs only on the falling edge. Random stimulus draws strobes and data from the full encoding, so both strobes sometimes arrive together. The assertions make no assumption about how often either strobe occurs.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;

    // exception indication positions in the operation vector
    localparam int EXC_W          = 7;
    localparam int EXC_INVALID    = 0;
    localparam int EXC_OVERFLOW   = 1;
    localparam int EXC_UNDERFLOW  = 2;
    localparam int EXC_OUT_DENORM = 3;
    localparam int EXC_DIVZERO    = 4;
    localparam int EXC_INEXACT    = 5;
    localparam int EXC_IN_DENORM  = 6;
    localparam int EXC_ARITH_W    = EXC_IN_DENORM; // bits counted by summary

    // sticky flag slots
    localparam int NUM_STICKY = 5;
    localparam int ST_INV     = 0;
    localparam int ST_OVF     = 1;
    localparam int ST_DZ      = 2;
    localparam int ST_UNF     = 3;
    localparam int ST_INX     = 4;

    // update-flags operand layout
    localparam int UPD_W        = 16;
    localparam int UPD_HALF     = UPD_W / 2;
    localparam int VAL_SUMMARY  = 7;
    localparam int VAL_INV      = 6;
    localparam int VAL_OVF      = 5;
    localparam int VAL_DZ       = 4;
    localparam int VAL_UNF      = 3;
    localparam int VAL_INX      = 2;
    localparam int MASK_INX     = 10;

    typedef logic [EXC_W-1:0] exc_vec_t;
    typedef logic [UPD_W-1:0] upd_word_t;

    typedef struct packed {
        logic                  summary;
        logic [NUM_STICKY-1:0] sticky;
    } flag_state_t;

    typedef struct packed {
        logic                  any;
        logic [NUM_STICKY-1:0] set;
    } op_effect_t;

    typedef struct packed {
        logic                  summary_val;
        logic [NUM_STICKY-1:0] load_en;
        logic [NUM_STICKY-1:0] load_val;
    } upd_effect_t;

    function automatic logic masked_bit(upd_word_t w, int vpos);
        return w[vpos] & w[vpos + UPD_HALF];
    endfunction

endpackage

// File: rtl/fpflag_op_decode.sv
module fpflag_op_decode
    import fpflag_pkg::*;
(
    input  exc_vec_t   exc_i,
    output op_effect_t eff_o
);
    logic [EXC_ARITH_W-1:0] arith;

    always_comb begin
        arith = exc_i[EXC_ARITH_W-1:0];
        eff_o.any          = |arith;
        eff_o.set[ST_INV]  = exc_i[EXC_INVALID];
        eff_o.set[ST_OVF]  = exc_i[EXC_OVERFLOW];
        eff_o.set[ST_DZ]   = exc_i[EXC_DIVZERO];
        eff_o.set[ST_UNF]  = exc_i[EXC_UNDERFLOW] | exc_i[EXC_OUT_DENORM];
        eff_o.set[ST_INX]  = exc_i[EXC_INEXACT]   | exc_i[EXC_OUT_DENORM];
    end

    logic unused_in_denorm;
    assign unused_in_denorm = exc_i[EXC_IN_DENORM];
endmodule

// File: rtl/fpflag_upd_decode.sv
module fpflag_upd_decode
    import fpflag_pkg::*;
(
    input  upd_word_t   word_i,
    output upd_effect_t eff_o
);
    always_comb begin
        eff_o.summary_val      = masked_bit(word_i, VAL_SUMMARY);
        eff_o.load_en          = '1;
        eff_o.load_val[ST_INV] = masked_bit(word_i, VAL_INV);
        eff_o.load_val[ST_OVF] = masked_bit(word_i, VAL_OVF);
        eff_o.load_val[ST_DZ]  = masked_bit(word_i, VAL_DZ);
        eff_o.load_val[ST_UNF] = masked_bit(word_i, VAL_UNF);
        // inexact has its own enable and takes the raw value bit
        eff_o.load_en[ST_INX]  = word_i[MASK_INX];
        eff_o.load_val[ST_INX] = word_i[VAL_INX];
    end

    logic unused_bits;
    assign unused_bits = ^{word_i[9:8], word_i[1:0]};
endmodule

// File: rtl/fpflag_store.sv
module fpflag_store
    import fpflag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_done,
    input  op_effect_t  op_eff,
    input  logic        upd_valid,
    input  upd_effect_t upd_eff,
    output flag_state_t state_o
);
    flag_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q.summary <= 1'b0;
        else if (upd_valid)
            state_q.summary <= upd_eff.summary_val;
        else if (op_done)
            state_q.summary <= op_eff.any;
    end

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)
                state_q.sticky[i] <= 1'b0;
            else if (upd_valid) begin
                if (upd_eff.load_en[i])
                    state_q.sticky[i] <= upd_eff.load_val[i];
            end else if (op_done && op_eff.set[i])
                state_q.sticky[i] <= 1'b1;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/fpflag_unit.sv
module fpflag_unit
    import fpflag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_done,
    input  logic [6:0]  op_exc,
    input  logic        upd_valid,
    input  logic [15:0] upd_operand,
    output logic        fl_summary,
    output logic        fl_invalid,
    output logic        fl_overflow,
    output logic        fl_divzero,
    output logic        fl_underflow,
    output logic        fl_inexact
);
    op_effect_t  op_eff;
    upd_effect_t upd_eff;
    flag_state_t st;

    fpflag_op_decode u_opdec (
        .exc_i (op_exc),
        .eff_o (op_eff)
    );

    fpflag_upd_decode u_upddec (
        .word_i (upd_operand),
        .eff_o  (upd_eff)
    );

    fpflag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .op_done   (op_done),
        .op_eff    (op_eff),
        .upd_valid (upd_valid),
        .upd_eff   (upd_eff),
        .state_o   (st)
    );

    assign fl_summary   = st.summary;
    assign fl_invalid   = st.sticky[ST_INV];
    assign fl_overflow  = st.sticky[ST_OVF];
    assign fl_divzero   = st.sticky[ST_DZ];
    assign fl_underflow = st.sticky[ST_UNF];
    assign fl_inexact   = st.sticky[ST_INX];
endmodule

// File: rtl/fpflag_unit_chk.sv
module fpflag_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_done,
    input logic [6:0]  op_exc,
    input logic        upd_valid,
    input logic [15:0] upd_operand,
    input logic        fl_summary,
    input logic        fl_invalid,
    input logic        fl_overflow,
    input logic        fl_divzero,
    input logic        fl_underflow,
    input logic        fl_inexact
);
    logic op_only;
    assign op_only = op_done && !upd_valid;

    AST_INV_SET: assert property (@(posedge clk) disable iff (rst)
        op_only && op_exc[0] |=> fl_invalid); // R2
    AST_DZ_SET: assert property (@(posedge clk) disable iff (rst)
        op_only && op_exc[4] |=> fl_divzero); // R2
    AST_UNF_SET: assert property (@(posedge clk) disable iff (rst)
        op_only && (op_exc[2] || op_exc[3]) |=> fl_underflow); // R3
    AST_INX_SET: assert property (@(posedge clk) disable iff (rst)
        op_only && (op_exc[5] || op_exc[3]) |=> fl_inexact); // R4
    AST_SUMMARY_OP: assert property (@(posedge clk) disable iff (rst)
        op_only |=> fl_summary == $past(|op_exc[5:0])); // R5
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !upd_valid && fl_overflow |=> fl_overflow); // R7
    AST_UPD_INVALID: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> fl_invalid == $past(upd_operand[6] & upd_operand[14])); // R8
    AST_UPD_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> fl_summary == $past(upd_operand[7] & upd_operand[15])); // R10
    AST_INX_MASKED: assert property (@(posedge clk) disable iff (rst)
        upd_valid && !upd_operand[10] |=> $stable(fl_inexact)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_done && !upd_valid |=> $stable({fl_summary, fl_invalid, fl_overflow,
                                            fl_divzero, fl_underflow, fl_inexact})); // R11
endmodule

bind fpflag_unit fpflag_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_done      (op_done),
    .op_exc       (op_exc),
    .upd_valid    (upd_valid),
    .upd_operand  (upd_operand),
    .fl_summary   (fl_summary),
    .fl_invalid   (fl_invalid),
    .fl_overflow  (fl_overflow),
    .fl_divzero   (fl_divzero),
    .fl_underflow (fl_underflow),
    .fl_inexact   (fl_inexact)
);

// File: tb/fpflag_unit_tb_top.sv
`timescale 1ns/1ps
module fpflag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_done = 1'b0;
    logic [6:0]  op_exc = '0;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_operand = '0;
    logic        fl_summary, fl_invalid, fl_overflow, fl_divzero, fl_underflow, fl_inexact;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    // reference model: bit order {summary, inv, ovf, dz, unf, inx}
    logic [5:0] model = '0;

    always #2 clk = ~clk;

    fpflag_unit dut_i (
        .clk(clk), .rst(rst), .op_done(op_done), .op_exc(op_exc),
        .upd_valid(upd_valid), .upd_operand(upd_operand),
        .fl_summary(fl_summary), .fl_invalid(fl_invalid), .fl_overflow(fl_overflow),
        .fl_divzero(fl_divzero), .fl_underflow(fl_underflow), .fl_inexact(fl_inexact)
    );

    function automatic logic [5:0] observed();
        return {fl_summary, fl_invalid, fl_overflow, fl_divzero, fl_underflow, fl_inexact};
    endfunction

    always @(posedge clk) begin
        if (rst) model = '0;
        else if (upd_valid) begin
            model[5] = upd_operand[7] & upd_operand[15];
            model[4] = upd_operand[6] & upd_operand[14];
            model[3] = upd_operand[5] & upd_operand[13];
            model[2] = upd_operand[4] & upd_operand[12];
            model[1] = upd_operand[3] & upd_operand[11];
            if (upd_operand[10]) model[0] = upd_operand[2];
        end else if (op_done) begin
            model[5] = |op_exc[5:0];
            if (op_exc[0]) model[4] = 1'b1;
            if (op_exc[1]) model[3] = 1'b1;
            if (op_exc[4]) model[2] = 1'b1;
            if (op_exc[2] || op_exc[3]) model[1] = 1'b1;
            if (op_exc[5] || op_exc[3]) model[0] = 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        checks++;
        if (observed() !== model) begin
            errors++;
            $display("FAIL %s model compare: actual=%b expected=%b", cur_req, observed(), model);
        end
    end

    task automatic expect_flags(input logic [5:0] exp, input string req);
        #1;
        checks++;
        if (observed() !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, observed(), exp);
        end
    endtask

    task automatic do_op(input logic [6:0] e);
        @(negedge clk); op_done = 1'b1; op_exc = e;
        @(negedge clk); op_done = 1'b0; op_exc = '0;
    endtask

    task automatic do_upd(input logic [15:0] w);
        @(negedge clk); upd_valid = 1'b1; upd_operand = w;
        @(negedge clk); upd_valid = 1'b0; upd_operand = '0;
    endtask

    initial begin
        #(4 * 50000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        expect_flags(6'b000000, "R1 in reset");
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        expect_flags(6'b000000, "R1 after release");

        cur_req = "R2";
        do_op(7'b0000001); expect_flags(6'b110000, "R2 invalid");
        cur_req = "R5";
        do_op(7'b0000000); expect_flags(6'b010000, "R5 summary cleared, R7 inv kept");
        cur_req = "R2";
        do_op(7'b0000010); expect_flags(6'b111000, "R2 overflow");
        do_op(7'b0010000); expect_flags(6'b111100, "R2 divzero");
        cur_req = "R3";
        do_op(7'b0000100); expect_flags(6'b111110, "R3 underflow");
        cur_req = "R4";
        do_op(7'b0100000); expect_flags(6'b111111, "R4 inexact");
        cur_req = "R11";
        repeat (3) @(negedge clk);
        expect_flags(6'b111111, "R11 idle hold");

        cur_req = "R8";
        do_upd(16'hFC00); expect_flags(6'b000000, "R8 R9 clear all");
        cur_req = "R6";
        do_op(7'b1000000); expect_flags(6'b000000, "R6 input denormal ignored");
        cur_req = "R3";
        do_op(7'b0001000); expect_flags(6'b100011, "R3 R4 output denormal");
        cur_req = "R9";
        do_upd(16'hF8F8); expect_flags(6'b111111, "R9 inexact held, R8 loads");
        do_upd(16'h04FF); expect_flags(6'b000001, "R8 zero mask");
        do_upd(16'h0400); expect_flags(6'b000000, "R9 inexact loaded 0");
        cur_req = "R10";
        @(negedge clk); op_done = 1'b1; op_exc = 7'b0111111;
        upd_valid = 1'b1; upd_operand = 16'h4040;
        @(negedge clk); op_done = 1'b0; upd_valid = 1'b0; op_exc = '0; upd_operand = '0;
        expect_flags(6'b010000, "R10 update wins");
        cur_req = "R7";
        do_op(7'b0000000); expect_flags(6'b010000, "R7 sticky kept");

        cur_req = "R11";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            op_done     = ($urandom % 3) == 0;
            op_exc      = 7'($urandom);
            upd_valid   = ($urandom % 5) == 0;
            upd_operand = 16'($urandom);
        end
        @(negedge clk); op_done = 1'b0; upd_valid = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        @(negedge clk);
        expect_flags(6'b000000, "R1 re-reset");
        rst = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule